// File: doc/BRIEF.md
# Dual-Character Serial Transmitter

This block takes a 20-bit parallel word made of two 10-bit transmission characters that are already line-coded. It sends the word out one bit per clock on a complementary output pair. Everything runs on the bit-rate clock. An internal modulo-20 phase counter marks the single cycle in which a word is accepted, and that cycle is shown on `word_stb`. The upstream logic presents the next word while the strobe is high. The block captures the word on the edge that closes that cycle. The first bit of the new word appears on the line immediately after that edge, so the last bit of one word is followed directly by the first bit of the next.

The block does not change the data. The lower ten bits form the first character and the upper ten bits form the second. Within each character, positions 0 to 9 carry the code letters a, b, c, d, e, i, f, g, h, j. A disable input parks the pair with the positive leg high and the negative leg low. A flag reports, for a whole word period, when the first character of the captured word starts with the comma alignment pattern or its inverse.

Top module: `dual_char_serializer`

## Requirements
- R1: After reset is released, `word_stb` is high in the first cycle and then in exactly one cycle out of every 20. A word is captured on the rising edge that ends a cycle in which `word_stb` is high.
- R2: When enabled, the line carries the captured word least significant bit first. Bit k of the captured word is on `ser_p` during the k-th cycle after the capture edge (k = 0..19), unchanged from the input.
- R3: While reset is inactive, `ser_n` is always the inverse of `ser_p`.
- R4: When `tx_off` was high at the previous rising edge, `ser_p` is 1 and `ser_n` is 0, whatever the data.
- R5: A change on `tx_off` takes effect at the next rising edge, at any bit position within the word and not only at a word boundary. Serialization continues in the background while the line is parked.
- R6: `comma_seen` becomes 1 after a capture edge when bits 6..0 of the captured word equal 7'b1111100, which is the letters a..f (with i) carrying 0,0,1,1,1,1,1.
- R7: `comma_seen` also becomes 1 when bits 6..0 equal the inverse pattern 7'b0000011. For any other value of those bits it becomes 0. Bits 7..19 have no effect on the flag.
- R8: `comma_seen` changes only on capture edges, so it holds its value for the full 20-cycle word period.
- R9: While `rst_n` is low at a rising edge, the block leaves that edge with `ser_p`=1, `ser_n`=0 and `comma_seen`=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit-rate clock |
| rst_n | input | 1 | Synchronous active-low reset |
| word_in | input | 20 | Two encoded characters; bits 9..0 are sent first |
| tx_off | input | 1 | Active-high line disable |
| word_stb | output | 1 | High in the cycle whose closing edge captures `word_in` |
| ser_p | output | 1 | Positive serial output |
| ser_n | output | 1 | Negative serial output |
| comma_seen | output | 1 | First character of the current word starts with a comma pattern |

## Verification
Three things can land on the same clock edge: a change on the disable input, a word capture, and the update of the comma flag. The bench provokes this by flipping `tx_off` in strobe cycles and in cycles just before and after them, while it feeds comma and inverse-comma words. The line must park or release on exactly that edge. The flag must still follow the newly captured word while the line is parked. When the line is released in the middle of a word, the bit that appears must be the one at the current position in the background shift.

// File: rtl/dcs_pkg.sv
// Package: shared constants and helpers for the dual-character serializer.
// Assumes characters are 10 bits and the comma prefix is 7 bits long.
package dcs_pkg;
    localparam int CHAR_W_DEF   = 10;
    localparam int N_CHARS_DEF  = 2;
    localparam int PREFIX_W_DEF = 7;

    // Comma prefix: letters a..f (with i) carry 0,0,1,1,1,1,1; bit 0 first.
    localparam logic [PREFIX_W_DEF-1:0] COMMA_PREFIX = 7'b1111100;

    // Return 1 when a prefix equals the comma prefix or its inverse.
    function automatic logic prefix_is_comma(input logic [PREFIX_W_DEF-1:0] v);
        return (v == COMMA_PREFIX) || (v == ~COMMA_PREFIX);
    endfunction
endpackage

// File: rtl/dcs_phase_ctr.sv
// Module: bit-phase counter. Counts bit times modulo WORD_W and raises
// load_now in phase zero. Assumes a synchronous active-low reset that
// returns the count to zero, so the first cycle after reset is a load cycle.
module dcs_phase_ctr #(
    parameter int WORD_W = 20,
    localparam int PH_W  = (WORD_W > 1) ? $clog2(WORD_W) : 1
) (
    input  logic clk,
    input  logic rst_n,
    output logic load_now
);
    localparam logic [PH_W-1:0] LAST_PH = PH_W'(WORD_W - 1);

    logic [PH_W-1:0] phase_q;

    // Advance the phase and wrap it after the last bit of the word.
    always_ff @(posedge clk) begin
        if (!rst_n)                phase_q <= '0;
        else if (phase_q == LAST_PH) phase_q <= '0;
        else                       phase_q <= phase_q + 1'b1;
    end

    // Phase zero is the cycle whose closing edge captures a word.
    always_comb load_now = (phase_q == '0);
endmodule

// File: rtl/dcs_shifter.sv
// Module: shift register, least significant bit first. On load it takes the
// whole word; otherwise it moves one place toward bit 0. cur_bit is the bit
// now on the line. Assumes load pulses at most once every WORD_W cycles.
module dcs_shifter #(
    parameter int WORD_W = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [WORD_W-1:0] word,
    output logic              cur_bit
);
    logic [WORD_W-1:0] sreg_q;
    logic [WORD_W-1:0] sreg_d;

    // Next-state value for each stage: parallel load or a move from above.
    generate
        for (genvar gi = 0; gi < WORD_W; gi++) begin : g_stage
            if (gi == WORD_W - 1) begin : g_top
                always_comb sreg_d[gi] = load ? word[gi] : 1'b0;
            end else begin : g_mid
                always_comb sreg_d[gi] = load ? word[gi] : sreg_q[gi+1];
            end
        end
    endgenerate

    // Register the shift stages.
    always_ff @(posedge clk) begin
        if (!rst_n) sreg_q <= '0;
        else        sreg_q <= sreg_d;
    end

    // Bit 0 is the bit being sent in this cycle.
    always_comb cur_bit = sreg_q[0];
endmodule

// File: rtl/dcs_comma_det.sv
// Module: comma detector for the first character of each captured word.
// It compares the low PREFIX_W bits of the word with the comma prefix and
// its inverse, and holds the result until the next load.
module dcs_comma_det #(
    parameter int WORD_W   = 20,
    parameter int PREFIX_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [WORD_W-1:0] word,
    output logic              hit
);
    import dcs_pkg::*;

    logic [PREFIX_W-1:0] prefix;
    logic                match;
    logic                hit_q;

    // Take out the leading letters of the first character.
    always_comb prefix = word[PREFIX_W-1:0];

    // Compare against both polarities of the comma prefix.
    always_comb match = prefix_is_comma(prefix);

    // Update the flag only when a word is captured.
    always_ff @(posedge clk) begin
        if (!rst_n)    hit_q <= 1'b0;
        else if (load) hit_q <= match;
    end

    always_comb hit = hit_q;
endmodule

// File: rtl/dcs_line_drv.sv
// Module: line driver. It registers the disable request once and forms the
// complementary pair. Reset leaves the line parked (positive high).
module dcs_line_drv (
    input  logic clk,
    input  logic rst_n,
    input  logic off_req,
    input  logic data_bit,
    output logic line_p,
    output logic line_n
);
    logic off_q;

    // Sample the disable request on every edge, not just at word boundaries.
    always_ff @(posedge clk) begin
        if (!rst_n) off_q <= 1'b1;
        else        off_q <= off_req;
    end

    // Park the pair or send the current bit, with true complements.
    always_comb begin
        line_p = off_q ? 1'b1 : data_bit;
        line_n = ~line_p;
    end
endmodule

// File: rtl/dual_char_serializer.sv
// Module: top of the dual-character serializer. It captures WORD_W bits
// (N_CHARS characters of CHAR_W bits) once per word period and sends them
// least significant bit first. It also flags a comma prefix in the first
// character. Assumes clk is the bit clock and the input data is already
// line-coded.
module dual_char_serializer #(
    parameter int CHAR_W   = 10,
    parameter int N_CHARS  = 2,
    parameter int PREFIX_W = 7,
    localparam int WORD_W  = CHAR_W * N_CHARS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] word_in,
    input  logic              tx_off,
    output logic              word_stb,
    output logic              ser_p,
    output logic              ser_n,
    output logic              comma_seen
);
    logic load_now;
    logic cur_bit;

    dcs_phase_ctr #(.WORD_W(WORD_W)) u_phase (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_now (load_now)
    );

    dcs_shifter #(.WORD_W(WORD_W)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load_now),
        .word    (word_in),
        .cur_bit (cur_bit)
    );

    dcs_comma_det #(.WORD_W(WORD_W), .PREFIX_W(PREFIX_W)) u_comma (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (load_now),
        .word  (word_in),
        .hit   (comma_seen)
    );

    dcs_line_drv u_line (
        .clk      (clk),
        .rst_n    (rst_n),
        .off_req  (tx_off),
        .data_bit (cur_bit),
        .line_p   (ser_p),
        .line_n   (ser_n)
    );

    // Tell the upstream logic which cycle's word will be captured.
    always_comb word_stb = load_now;
endmodule

// File: rtl/dcs_checker.sv
// Module: assertion checker bound to dual_char_serializer. It watches
// the ports only. A counter measures the gap between strobes, so no
// parameter-sized delay is needed.
module dcs_checker #(
    parameter int WORD_W = 20
) (
    input logic              clk,
    input logic              rst_n,
    input logic [WORD_W-1:0] word_in,
    input logic              tx_off,
    input logic              word_stb,
    input logic              ser_p,
    input logic              ser_n,
    input logic              comma_seen
);
    logic [15:0] gap_q;
    logic        seen_q;

    // Count the cycles since the last strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap_q  <= '0;
            seen_q <= 1'b0;
        end else if (word_stb) begin
            gap_q  <= '0;
            seen_q <= 1'b1;
        end else begin
            gap_q  <= gap_q + 1'b1;
        end
    end

    AST_STB_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
        (word_stb && seen_q) |-> (gap_q == 16'(WORD_W - 1)));  // R1
    AST_FIRST_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        (word_stb && !tx_off) |=> (ser_p == $past(word_in[0])));  // R2
    AST_PAIR_OPPOSITE: assert property (@(posedge clk) disable iff (!rst_n)
        ser_p != ser_n);  // R3
    AST_OFF_PARKS: assert property (@(posedge clk) disable iff (!rst_n)
        tx_off |=> (ser_p && !ser_n));  // R4
    AST_COMMA_POS: assert property (@(posedge clk) disable iff (!rst_n)
        (word_stb && (word_in[6:0] == 7'b1111100)) |=> comma_seen);  // R6
    AST_COMMA_NEG: assert property (@(posedge clk) disable iff (!rst_n)
        (word_stb && (word_in[6:0] == 7'b0000011)) |=> comma_seen);  // R7
    AST_COMMA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !word_stb |=> $stable(comma_seen));  // R8
endmodule

bind dual_char_serializer dcs_checker #(.WORD_W(WORD_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .word_in    (word_in),
    .tx_off     (tx_off),
    .word_stb   (word_stb),
    .ser_p      (ser_p),
    .ser_n      (ser_n),
    .comma_seen (comma_seen)
);

// File: tb/dual_char_serializer_test.sv
// Bench: random words and disable toggles with a fixed seed, plus directed
// comma and boundary cases. A bench-side model is built from the
// requirements. Outputs are sampled on the falling edge.
module dual_char_serializer_test;
    localparam int W = 20;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] word_in = '0;
    logic         tx_off = 1'b0;
    logic         word_stb, ser_p, ser_n, comma_seen;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    // Model state
    int           m_phase = 0;
    int           m_idx = 0;
    logic [W-1:0] m_word = '0;
    logic         m_comma = 1'b0;
    logic         m_off_prev = 1'b1;

    always #4 clk = ~clk;  // 125 MHz

    dual_char_serializer uut (
        .clk(clk), .rst_n(rst_n), .word_in(word_in), .tx_off(tx_off),
        .word_stb(word_stb), .ser_p(ser_p), .ser_n(ser_n), .comma_seen(comma_seen)
    );

    function automatic logic is_comma(input logic [W-1:0] w);
        return (w[6:0] == 7'b1111100) || (w[6:0] == 7'b0000011);
    endfunction

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0b expected=%0b at %0t", req, act, exp, $time);
        end
    endtask

    // Run one clock with the given inputs, then compare outputs with the model.
    task automatic cycle(input logic [W-1:0] w, input logic off);
        logic exp_p;
        string tag;
        word_in = w;
        tx_off  = off;
        check("R1 word_stb", word_stb, (m_phase == 0));
        @(posedge clk);
        if (m_phase == 0) begin
            m_word  = w;
            m_idx   = 0;
            m_comma = is_comma(w);
        end
        exp_p   = off ? 1'b1 : m_word[m_idx];
        tag     = (off != m_off_prev) ? "R5" : (off ? "R4" : "R2");
        m_idx   = m_idx + 1;
        m_phase = (m_phase + 1) % W;
        m_off_prev = off;
        @(negedge clk);
        check({tag, " ser_p"}, ser_p, exp_p);
        check("R3 ser_n", ser_n, ~exp_p);
        check((m_word[6:0] == 7'b0000011) ? "R7 comma" :
              (m_word[6:0] == 7'b1111100) ? "R6 comma" : "R8 comma",
              comma_seen, m_comma);
    endtask

    // Send one full word; off_at selects a cycle in which the disable flips (-1: none).
    task automatic send_word(input logic [W-1:0] w, input logic off0, input int off_at);
        logic off;
        off = off0;
        for (int k = 0; k < W; k++) begin
            if (k == off_at) off = ~off;
            cycle(w, off);
        end
    endtask

    initial begin
        int unused;
        logic [W-1:0] w;
        unused = $urandom(32'h5EED_0042);
        // Reset state (R9)
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R9 ser_p", ser_p, 1'b1);
        check("R9 ser_n", ser_n, 1'b0);
        check("R9 comma", comma_seen, 1'b0);
        rst_n = 1'b1;

        // Directed words: comma (R6), inverse comma (R7), upper-bit noise (R7)
        send_word(20'h0007C, 1'b0, -1);
        send_word(20'hFFC03, 1'b0, -1);
        send_word(20'h5557D, 1'b0, -1);
        send_word(20'hAAA7C, 1'b0, -1);
        send_word(20'h00000, 1'b0, -1);
        send_word(20'hFFFFF, 1'b0, -1);
        send_word(20'h80001, 1'b0, -1);
        // Parked while a comma is captured, released mid-word (R4, R5, R6)
        send_word(20'h1237C, 1'b1, 9);
        // Disable raised in the capture cycle itself (R5)
        send_word(20'hC3A03, 1'b0, 0);
        send_word(20'h2468B, 1'b1, 0);
        send_word(20'h13579, 1'b0, 19);
        send_word(20'h9BD7C, 1'b1, 1);

        // Constrained random words
        for (int n = 0; n < 300; n++) begin
            w = W'($urandom());
            case ($urandom() % 4)
                0: w[6:0] = 7'b1111100;
                1: w[6:0] = 7'b0000011;
                default: ;
            endcase
            send_word(w, ($urandom() % 6) == 0,
                      (($urandom() % 3) == 0) ? int'($urandom() % W) : -1);
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule